// File: doc/BRIEF.md
# Watchdog Counter with Cross-Domain Write Tracking

This block is a watchdog that runs on a slow, free-running clock of about 32 kHz. Software programs it over a simple register bus on the fast bus clock, using one write strobe, an address and write data, with read data returned combinationally for the current address. The watchdog counter counts upward, stepped by a power-of-two prescaler. If software fails to service it, the counter passes all ones. It then reloads itself from the load value and raises a one-slow-cycle reset pulse. Software services the watchdog by writing a new value to the trigger register. A start/stop register only changes the running state after a correct two-word sequence.

Every register that lives in the slow domain has its own write-pending flag. A bus write is held in that register's private holding stage and announced by a toggle that is synchronised into the slow clock. The write is applied there, and the acknowledgement comes back through two bus-clock flops. Software polls the status word until the flag drops before it writes the same register again. A write that arrives while the flag is still up is dropped.

The run/stop control is the state machine `wdt_arm_fsm`. It has four states. In `ST_OFF` the watchdog is disarmed and idle. In `ST_OFF_W1` it is disarmed and the first enable word has been seen. In `ST_ON` it is armed. In `ST_ON_W1` it is armed and the first disable word has been seen. The transitions are listed below.

- `ST_OFF` goes to `ST_OFF_W1` on the first enable word.
- `ST_OFF_W1` goes to `ST_ON` on the second enable word.
- `ST_ON` goes to `ST_ON_W1` on the first disable word.
- `ST_ON_W1` goes to `ST_OFF` on the second disable word.
- Any other start/stop write taken in `ST_OFF_W1` returns to `ST_OFF`.
- Any other start/stop write taken in `ST_ON_W1` returns to `ST_ON`.
- Any non-matching write taken in `ST_OFF` or `ST_ON` keeps the state.

Top module: `wdt_xdom`

## Requirements
- R1: After reset the watchdog is disarmed. Addresses 0 to 5 all read zero, the status word reads zero and `wd_rst` is low.
- R2: The register map is address 0 control, 1 counter, 2 load, 3 trigger, 4 start/stop and 5 status. Status bits 0 to 4 are the pending flags of addresses 0 to 4 in that order. A flag rises on the bus edge that accepts a write. It falls two bus-clock cycles after the slow domain has applied that write.
- R3: A write to a register whose pending flag is set has no effect.
- R4: Writing 0x0000BBBB and then 0x00004444 to the start/stop register, with no other start/stop write between them, arms the watchdog.
- R5: Writing 0x0000AAAA and then 0x00005555 to the start/stop register, with no other start/stop write between them, disarms it. The counter then stops and no further reset pulses occur.
- R6: A start/stop write that does not continue a sequence leaves the armed state unchanged and clears the sequence. This covers a wrong value, a repeated first word, and a second word without its first word directly before it.
- R7: While armed, the counter steps by one per tick. Control bit 4 enables the prescaler and control bits 2:0 hold the ratio r. With the prescaler enabled a tick occurs every 2^r slow cycles, and with it disabled a tick occurs every slow cycle. So the time between reset pulses is (2^32 − load) × 2^r slow cycles, with r taken as 0 when the prescaler is disabled.
- R8: A tick taken at a count of all ones reloads the count from the load register and drives `wd_rst` high for exactly one slow cycle, when the load is not all ones.
- R9: A trigger write whose value differs from the held trigger value reloads the count from the load register and restarts the prescaler, with no reset pulse. A trigger write of the same value reloads nothing.
- R10: While the watchdog is armed, writes to the control, counter and load registers are ignored.
- R11: Each register reads back the last value that took effect. The counter reads back the live count.
- R12: A counter value of all ones gives a reset pulse on the first tick after arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| slow_clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wd_rst | output | 1 | Reset pulse, slow-clock domain |

## Verification
On every cycle, the assertions check the rules that are local to each domain. They check that the pending flag rises on an accepted write and that a dropped write leaves the holding stage untouched. They check that the armed state only moves on the closing word of a sequence, that the count steps by one, and that overflow reloads and pulses. They also check that a trigger reload never pulses and that load and control stay frozen while armed. Only the bench scenarios can show the behaviour that spans both clocks. That means the handshake latency seen in the status word, the exact pulse spacing for each prescaler setting and load value, the effect of servicing against not servicing the watchdog, and the live counter value read back over the bus.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int NREG      = 5;
    localparam int IDX_CTRL  = 0;
    localparam int IDX_CNT   = 1;
    localparam int IDX_LOAD  = 2;
    localparam int IDX_TRIG  = 3;
    localparam int IDX_ARM   = 4;
    localparam int ADDR_STAT = 5;
    localparam int CTRL_EN_BIT = 4;

    localparam logic [31:0] ARM_W1 = 32'h0000_BBBB;
    localparam logic [31:0] ARM_W2 = 32'h0000_4444;
    localparam logic [31:0] DIS_W1 = 32'h0000_AAAA;
    localparam logic [31:0] DIS_W2 = 32'h0000_5555;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_OFF_W1 = 2'd1,
        ST_ON     = 2'd2,
        ST_ON_W1  = 2'd3
    } arm_state_e;
endpackage

// File: rtl/wdt_wr_chan.sv
// One bus-to-slow write channel: private holding stage, request toggle,
// three-flop slow capture, two-flop acknowledge back into the bus clock.
module wdt_wr_chan #(
    parameter int DW = 32
) (
    input  logic          bus_clk,
    input  logic          slow_clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic          pend,
    output logic          apply,
    output logic [DW-1:0] data
);
    logic          req_t;
    logic [DW-1:0] hold;
    logic          ack_b1, ack_b2;
    logic          s1, s2, s3;

    assign pend  = req_t ^ ack_b2;
    assign apply = s2 ^ s3;
    assign data  = hold;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_t  <= 1'b0;
            hold   <= '0;
            ack_b1 <= 1'b0;
            ack_b2 <= 1'b0;
        end else begin
            if (wr_hit && !pend) begin
                hold  <= wdata;
                req_t <= ~req_t;
            end
            ack_b1 <= s3;
            ack_b2 <= ack_b1;
        end
    end

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= req_t;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // R2: an accepted write raises the pending flag
    p_pend_set_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (wr_hit && !pend) |=> pend);
    // R3: a write landing on a pending channel leaves the holding stage alone
    p_drop_pending_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (wr_hit && pend) |=> $stable(hold));
endmodule

// File: rtl/wdt_arm_fsm.sv
module wdt_arm_fsm
    import wdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          slow_clk,
    input  logic          rst_n,
    input  logic          apply,
    input  logic [DW-1:0] word,
    output logic          armed
);
    arm_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (apply) begin
            unique case (state)
                ST_OFF:    state_nx = (word == DW'(ARM_W1)) ? ST_OFF_W1 : ST_OFF;
                ST_OFF_W1: state_nx = (word == DW'(ARM_W2)) ? ST_ON     : ST_OFF;
                ST_ON:     state_nx = (word == DW'(DIS_W1)) ? ST_ON_W1  : ST_ON;
                ST_ON_W1:  state_nx = (word == DW'(DIS_W2)) ? ST_OFF    : ST_ON;
                default:   state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_ON, ST_ON_W1: armed = 1'b1;
            default:         armed = 1'b0;
        endcase
    end

    // R4: arming only ever follows the closing enable word
    p_arm_close_r4: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $rose(armed) |-> $past(apply && (word == DW'(ARM_W2))));
    // R5: disarming only ever follows the closing disable word
    p_disarm_close_r5: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $fell(armed) |-> $past(apply && (word == DW'(DIS_W2))));
    // R6: without a start/stop write the running state holds
    p_arm_hold_r6: assert property (@(posedge slow_clk) disable iff (!rst_n)
        !apply |=> $stable(armed));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             en,
    input  logic [PRE_W-1:0] ratio,
    output logic             tick
);
    localparam int PDW = (1 << PRE_W) - 1;

    logic [PDW-1:0] pcnt;
    logic [PDW:0]   span;

    assign span = (PDW+1)'(1) << ratio;
    assign tick = run && (!en || ({1'b0, pcnt} == (span - 1'b1)));

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n)              pcnt <= '0;
        else if (!run || clr)    pcnt <= '0;
        else if (tick)           pcnt <= '0;
        else if (en)             pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int PRE_W = 3
) (
    input  logic                     slow_clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          apply,
    input  logic [NREG-1:0][DW-1:0]  xdata,
    input  logic                     armed,
    input  logic                     tick,
    output logic                     pre_clr,
    output logic                     pre_en,
    output logic [PRE_W-1:0]         pre_ratio,
    output logic [DW-1:0]            count,
    output logic [DW-1:0]            load_q,
    output logic [DW-1:0]            trig_q,
    output logic [DW-1:0]            arm_q,
    output logic                     wd_rst
);
    logic trig_reload;
    logic ovf;
    logic ctrl_unused;

    assign trig_reload = apply[IDX_TRIG] && (xdata[IDX_TRIG] != trig_q);
    assign ovf         = armed && tick && (count == '1) && !trig_reload;
    assign pre_clr     = trig_reload;
    assign ctrl_unused = ^{xdata[IDX_CTRL][DW-1:CTRL_EN_BIT+1],
                           xdata[IDX_CTRL][CTRL_EN_BIT-1:PRE_W]};

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_en    <= 1'b0;
            pre_ratio <= '0;
            load_q    <= '0;
            trig_q    <= '0;
            arm_q     <= '0;
            count     <= '0;
            wd_rst    <= 1'b0;
        end else begin
            if (apply[IDX_TRIG]) trig_q <= xdata[IDX_TRIG];
            if (apply[IDX_ARM])  arm_q  <= xdata[IDX_ARM];
            if (apply[IDX_LOAD] && !armed) load_q <= xdata[IDX_LOAD];
            if (apply[IDX_CTRL] && !armed) begin
                pre_en    <= xdata[IDX_CTRL][CTRL_EN_BIT];
                pre_ratio <= xdata[IDX_CTRL][PRE_W-1:0];
            end
            if (trig_reload)                    count <= load_q;
            else if (apply[IDX_CNT] && !armed)  count <= xdata[IDX_CNT];
            else if (ovf)                       count <= load_q;
            else if (armed && tick)             count <= count + 1'b1;
            wd_rst <= ovf;
        end
    end

    // R7: an ordinary tick advances the count by exactly one
    p_count_step_r7: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (armed && tick && (count != '1) && !trig_reload) |=> (count == $past(count) + 1'b1));
    // R8: overflow reloads from the load register and raises the reset pulse
    p_ovf_reload_r8: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (armed && tick && (count == '1) && !trig_reload) |=> (wd_rst && (count == $past(load_q))));
    // R8: no pulse unless the watchdog was armed
    p_pulse_armed_r8: assert property (@(posedge slow_clk) disable iff (!rst_n)
        wd_rst |-> $past(armed));
    // R9: a servicing reload never pulses
    p_trig_quiet_r9: assert property (@(posedge slow_clk) disable iff (!rst_n)
        trig_reload |=> (!wd_rst && (count == $past(load_q))));
    // R10: load and prescaler setting stay frozen while armed
    p_frozen_load_r10: assert property (@(posedge slow_clk) disable iff (!rst_n)
        armed |=> ($stable(load_q) && $stable(pre_ratio) && $stable(pre_en)));
endmodule

// File: rtl/wdt_snap.sv
// Ping-pong snapshot of the live count into the bus domain.
module wdt_snap #(
    parameter int DW = 32
) (
    input  logic          slow_clk,
    input  logic          bus_clk,
    input  logic          rst_n,
    input  logic [DW-1:0] value,
    output logic [DW-1:0] rd_value
);
    logic [DW-1:0] snap_q;
    logic          snap_tgl, ack_s1, ack_s2;
    logic          tg_b1, tg_b2, ack_b;

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q   <= '0;
            snap_tgl <= 1'b0;
            ack_s1   <= 1'b0;
            ack_s2   <= 1'b0;
        end else begin
            ack_s1 <= ack_b;
            ack_s2 <= ack_s1;
            if (ack_s2 == snap_tgl) begin
                snap_q   <= value;
                snap_tgl <= ~snap_tgl;
            end
        end
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            tg_b1    <= 1'b0;
            tg_b2    <= 1'b0;
            ack_b    <= 1'b0;
            rd_value <= '0;
        end else begin
            tg_b1 <= snap_tgl;
            tg_b2 <= tg_b1;
            if (tg_b2 != ack_b) begin
                rd_value <= snap_q;
                ack_b    <= tg_b2;
            end
        end
    end
endmodule

// File: rtl/wdt_xdom.sv
module wdt_xdom
    import wdt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 3,
    parameter int PRE_W = 3
) (
    input  logic          bus_clk,
    input  logic          slow_clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wd_rst
);
    logic [NREG-1:0]         wr_hit, pend, apply;
    logic [NREG-1:0][DW-1:0] xdata;
    logic                    armed, tick, pre_clr, pre_en;
    logic [PRE_W-1:0]        pre_ratio;
    logic [DW-1:0]           count, load_q, trig_q, arm_q, count_rd, ctrl_rd;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_chan
        assign wr_hit[gi] = bus_wr && (bus_addr == AW'(gi));
        wdt_wr_chan #(.DW(DW)) u_chan (
            .bus_clk (bus_clk),
            .slow_clk(slow_clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[gi]),
            .wdata   (bus_wdata),
            .pend    (pend[gi]),
            .apply   (apply[gi]),
            .data    (xdata[gi])
        );
    end

    wdt_arm_fsm #(.DW(DW)) u_fsm (
        .slow_clk(slow_clk),
        .rst_n   (rst_n),
        .apply   (apply[IDX_ARM]),
        .word    (xdata[IDX_ARM]),
        .armed   (armed)
    );

    wdt_prescale #(.PRE_W(PRE_W)) u_pre (
        .slow_clk(slow_clk),
        .rst_n   (rst_n),
        .run     (armed),
        .clr     (pre_clr),
        .en      (pre_en),
        .ratio   (pre_ratio),
        .tick    (tick)
    );

    wdt_core #(.DW(DW), .PRE_W(PRE_W)) u_core (
        .slow_clk (slow_clk),
        .rst_n    (rst_n),
        .apply    (apply),
        .xdata    (xdata),
        .armed    (armed),
        .tick     (tick),
        .pre_clr  (pre_clr),
        .pre_en   (pre_en),
        .pre_ratio(pre_ratio),
        .count    (count),
        .load_q   (load_q),
        .trig_q   (trig_q),
        .arm_q    (arm_q),
        .wd_rst   (wd_rst)
    );

    wdt_snap #(.DW(DW)) u_snap (
        .slow_clk(slow_clk),
        .bus_clk (bus_clk),
        .rst_n   (rst_n),
        .value   (count),
        .rd_value(count_rd)
    );

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[PRE_W-1:0]  = pre_ratio;
        ctrl_rd[CTRL_EN_BIT] = pre_en;
    end

    // Slow-domain registers are quasi-static once their pending flag is low.
    always_comb begin
        case (bus_addr)
            AW'(IDX_CTRL):  bus_rdata = ctrl_rd;
            AW'(IDX_CNT):   bus_rdata = count_rd;
            AW'(IDX_LOAD):  bus_rdata = load_q;
            AW'(IDX_TRIG):  bus_rdata = trig_q;
            AW'(IDX_ARM):   bus_rdata = arm_q;
            AW'(ADDR_STAT): bus_rdata = DW'(pend);
            default:        bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/tb_wdt_xdom.sv
`timescale 1ns/1ps
module tb_wdt_xdom;
    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_rst;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;

    wdt_xdom dut (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wd_rst(wd_rst)
    );

    always #2 bus_clk = ~bus_clk;
    initial begin
        #7;
        forever #20 slow_clk = ~slow_clk;
    end

    always @(negedge slow_clk) if (wd_rst === 1'b1) pulse_cnt++;

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = 3'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_clear(input int a, output int cyc);
        logic [31:0] s;
        cyc = 0;
        for (int k = 0; k < 400; k++) begin
            rd(5, s);
            if (s[a] == 1'b0) break;
            cyc++;
        end
    endtask

    task automatic wrs(input int a, input logic [31:0] d);
        int c;
        wr(a, d);
        wait_clear(a, c);
    endtask

    task automatic slow_wait(input int n);
        for (int k = 0; k < n; k++) @(negedge slow_clk);
    endtask

    task automatic arm();
        wrs(4, 32'h0000_BBBB); wrs(4, 32'h0000_4444);
    endtask

    task automatic disarm();
        wrs(4, 32'h0000_AAAA); wrs(4, 32'h0000_5555);
    endtask

    // Measure pulse width and the spacing between two consecutive pulses.
    task automatic measure(output int width, output int gap);
        int t;
        width = 0; gap = 0;
        t = 0;
        while (wd_rst !== 1'b1 && t < 6000) begin @(negedge slow_clk); t++; end
        t = 0;
        while (wd_rst === 1'b1 && t < 6000) begin width++; @(negedge slow_clk); t++; end
        gap = width;
        while (wd_rst !== 1'b1 && gap < 6000) begin @(negedge slow_clk); gap++; end
    endtask

    task automatic sweep(input bit pe, input int r, input logic [31:0] ld);
        int w, g;
        longint exp;
        disarm();
        wrs(0, {27'b0, pe, 1'b0, 3'(r)});
        wrs(2, ld);
        wrs(1, ld);
        arm();
        measure(w, g);
        exp = (64'h1_0000_0000 - longint'(ld)) * (pe ? (64'd1 << r) : 64'd1);
        chk("R7 pulse spacing", longint'(g) == exp, g, exp);
        chk("R8 pulse width", w == 1, w, 1);
    endtask

    initial begin
        #750_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int c, p0;
        #30 rst_n = 1'b1;
        slow_wait(3);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v);
            chk("R1 reset readback", v == 32'h0, v, 0);
        end
        chk("R1 wd_rst low", wd_rst == 1'b0, wd_rst, 0);

        // R2 pending flag set then cleared
        wr(2, 32'h0000_1111);
        rd(5, v);
        chk("R2 pending bit load only", v == 32'h4, v, 4);
        wait_clear(2, c);
        chk("R2 pending clears in window", c >= 6 && c <= 60, c, 20);

        // R3 write while pending dropped
        wr(2, 32'h0000_2222);
        wr(2, 32'h0000_3333);
        wait_clear(2, c);
        rd(2, v);
        chk("R3 second write dropped", v == 32'h0000_2222, v, 32'h2222);

        // R11 readback of written values
        wrs(0, 32'h0000_0015);
        rd(0, v);
        chk("R11 control readback", v == 32'h15, v, 32'h15);
        wrs(3, 32'h0000_00A5);
        rd(3, v);
        chk("R11 trigger readback", v == 32'hA5, v, 32'hA5);
        wrs(0, 32'h0);
        wrs(2, 32'h0);
        wrs(1, 32'h0000_0100);
        slow_wait(12);
        rd(1, v);
        chk("R11 counter readback disarmed", v == 32'h100, v, 32'h100);

        // R6 broken sequences leave it disarmed
        wrs(4, 32'h0000_4444);
        slow_wait(20); rd(1, v);
        chk("R6 lone second word", v == 32'h100, v, 32'h100);
        wrs(4, 32'h0000_BBBB); wrs(4, 32'h0000_1234); wrs(4, 32'h0000_4444);
        slow_wait(20); rd(1, v);
        chk("R6 wrong word between", v == 32'h100, v, 32'h100);
        wrs(4, 32'h0000_BBBB); wrs(4, 32'h0000_BBBB); wrs(4, 32'h0000_4444);
        slow_wait(20); rd(1, v);
        chk("R6 repeated first word", v == 32'h100, v, 32'h100);
        rd(4, v);
        chk("R11 start/stop readback", v == 32'h4444, v, 32'h4444);

        // R4 arm, R7 counting rate
        arm();
        slow_wait(10);
        rd(1, v);
        slow_wait(50);
        rd(1, v2);
        chk("R4 armed counter moves", v2 > 32'h100, v2, 32'h100);
        chk("R7 one step per slow cycle", (v2 - v) >= 44 && (v2 - v) <= 56, v2 - v, 50);

        // R10 writes ignored while armed
        wrs(2, 32'h0000_0055);
        rd(2, v);
        chk("R10 load ignored", v == 32'h0, v, 0);
        wrs(0, 32'h0000_0013);
        rd(0, v);
        chk("R10 control ignored", v == 32'h0, v, 0);
        rd(1, v);
        wrs(1, 32'h0000_0005);
        slow_wait(10);
        rd(1, v2);
        chk("R10 counter write ignored", v2 > v, v2, v);

        // R6 broken disarm keeps running
        wrs(4, 32'h0000_AAAA); wrs(4, 32'h0000_1111); wrs(4, 32'h0000_5555);
        rd(1, v); slow_wait(30); rd(1, v2);
        chk("R6 broken disarm still running", v2 > v, v2, v);

        // R5 disarm stops counting
        disarm();
        slow_wait(10);
        p0 = pulse_cnt;
        rd(1, v); slow_wait(60); rd(1, v2);
        chk("R5 counter frozen", v2 == v, v2, v);
        chk("R5 no pulses", pulse_cnt == p0, pulse_cnt, p0);

        // R7/R8 sweep over prescaler settings and load values
        sweep(1'b0, 0, 32'hFFFF_FFF0);
        sweep(1'b0, 0, 32'hFFFF_FFFA);
        sweep(1'b0, 0, 32'hFFFF_FFFE);
        for (int r = 0; r < 4; r++) sweep(1'b1, r, 32'hFFFF_FFF0);
        sweep(1'b1, 7, 32'hFFFF_FFFE);

        // R9 servicing with changing values suppresses pulses
        disarm();
        wrs(0, 32'h0);
        wrs(2, 32'hFFFF_FF00);
        wrs(1, 32'hFFFF_FF00);
        arm();
        p0 = pulse_cnt;
        for (int i = 0; i < 8; i++) begin
            slow_wait(150);
            wrs(3, 32'(i + 100));
        end
        chk("R9 serviced no pulses", pulse_cnt == p0, pulse_cnt, p0);
        p0 = pulse_cnt;
        for (int i = 0; i < 6; i++) begin
            slow_wait(150);
            wrs(3, 32'd107);
        end
        chk("R9 same value does not reload", pulse_cnt >= p0 + 2, pulse_cnt, p0 + 3);
        rd(3, v);
        chk("R11 trigger holds last value", v == 32'd107, v, 107);

        // R12 all-ones counter overflows on first tick
        disarm();
        wrs(2, 32'hFFFF_FF00);
        wrs(1, 32'hFFFF_FFFF);
        wrs(4, 32'h0000_BBBB);
        p0 = pulse_cnt;
        wrs(4, 32'h0000_4444);
        slow_wait(3);
        chk("R12 immediate reset pulse", pulse_cnt == p0 + 1, pulse_cnt, p0 + 1);
        disarm();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule